// File: doc/BRIEF.md
# Protected Flash Write Controller

This block is a synthesizable behavioural model of a small NOR-style flash array with a command port and a write engine. It tracks when that engine is busy. The array is split into equal blocks of words, and a small one-time-programmable (OTP) word region sits beside it. The host issues one command per cycle on a valid-qualified bus. It learns of completion by polling a ready flag in an 8-bit status byte. Contents are read through a separate combinational read port.

Every modifying operation passes through a permission gate first. The gate checks a per-block lock flag and a per-block freeze (lock-down) flag. It also checks an active-low write-protect pin, a supply-lockout flag and the reset pin. Programming can only move bits from 1 to 0. Erase returns words to all ones. A rejected command leaves a sticky error flag that only a clear command removes. The busy period is a fixed cycle count that is longer for erase than for program.

Top module: `flash_prot_ctrl`

## Requirements
- R1: An accepted program (op 1), block erase (op 2), chip erase (op 3) or OTP program (op 4) drops status bit 7 to 0 at the accepting clock edge. Bit 7 returns to 1 after exactly PROG_CYC cycles for ops 1 and 4, and after exactly ERASE_CYC cycles for ops 2 and 3.
- R2: Status bit 7 reads 1 whenever the engine is idle and throughout reset. Status is 8'h80 in reset: bit 7 is ready, bit 4 is error, and all other bits are 0.
- R3: A completed program (op 1) stores the old word AND the written word. A 1 in the written word leaves that bit unchanged. For example, 8'hBD programmed with 8'hFE gives 8'hBC.
- R4: A block erase (op 2) sets every word of the block chosen by the upper address bits to all ones. Other blocks are left alone.
- R5: A chip erase (op 3) sets every word of every unlocked block to all ones. Locked blocks keep their data.
- R6: A program or block erase aimed at a locked block is rejected. The rejected command never makes the engine busy, leaves the data unchanged, and sets status bit 4.
- R7: A lock set (op 5) or lock clear (op 6) on a block whose freeze flag is set is rejected while wp_n is low. It is accepted while wp_n is high. Blocks without the freeze flag accept both ops at any wp_n level.
- R8: After reset every block is locked and every freeze flag is clear. A freeze flag is set by op 7 and is cleared only by reset.
- R9: While supply_low is high, ops 1 to 4 are rejected, including OTP program. If supply_low is high in the cycle an operation completes, no data changes and status bit 4 is set.
- R10: While rst_n is low, commands are ignored. Reset returns every array word and every OTP word to all ones.
- R11: Status bit 4 stays set across later successful commands until a clear command (op 0) is accepted.
- R12: An OTP program (op 4) stores the old OTP word AND the written word, at the OTP word chosen by the low address bits. OTP programming ignores block locks, and a chip erase never changes OTP words.
- R13: A command presented while the engine is busy is ignored. This covers program commands and lock changes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; while low, reset mode inhibits all writes |
| wp_n | input | 1 | Active-low write-protect; when low, freeze flags apply |
| supply_low | input | 1 | Supply lockout flag; when high, all writes are disabled |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code 0..7 |
| cmd_addr | input | AW (4) | Word address: block in the upper bits, word in the lower bits; OTP word in the low bits |
| cmd_data | input | DATA_W (8) | Program data |
| rd_otp | input | 1 | Read port selects the OTP region |
| rd_addr | input | AW (4) | Read address |
| rd_data | output | DATA_W (8) | Read data, combinational |
| status | output | 8 | Bit 7 ready, bit 4 error |

## Verification
Programming is exercised with three data patterns against a known stored word. The first pattern clears several bits of an erased word. The second clears a single bit and must match the AND rule. The third is all ones and must leave the word unchanged. Together they separate a true AND from a plain overwrite or an OR. Erase is tried with a mix of locked and unlocked blocks, so that a block-scoped erase can be told apart from a chip-wide one, and a lock-honouring chip erase from one that ignores locks. The protection inputs are applied one at a time, and supply lockout is also raised in the middle of a busy period, so each gating path is observed on its own. Busy-cycle counts are measured for both the program and the erase lengths.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  typedef enum logic [2:0] {
    OP_CLRSTAT = 3'd0,
    OP_PROG    = 3'd1,
    OP_BERASE  = 3'd2,
    OP_CERASE  = 3'd3,
    OP_OTPPROG = 3'd4,
    OP_LOCK    = 3'd5,
    OP_UNLOCK  = 3'd6,
    OP_FREEZE  = 3'd7
  } fop_e;

  // Ops that occupy the write engine
  function automatic logic is_engine_op(fop_e op);
    return (op == OP_PROG) || (op == OP_BERASE) ||
           (op == OP_CERASE) || (op == OP_OTPPROG);
  endfunction

  // Ops that use the short busy length
  function automatic logic is_short_op(fop_e op);
    return (op == OP_PROG) || (op == OP_OTPPROG);
  endfunction

endpackage

// File: rtl/flashctl_gate.sv
module flashctl_gate
  import flashctl_pkg::*;
#(
  parameter int NBLK = 4,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  fop_e            op,
  input  logic [BW-1:0]   blk,
  input  logic [NBLK-1:0] lock,
  input  logic [NBLK-1:0] freeze,
  input  logic            wp_n,
  input  logic            supply_low,
  output logic            start_ok,
  output logic            lock_ok,
  output logic            reject
);

  always_comb begin
    start_ok = 1'b0;
    lock_ok  = 1'b0;
    reject   = 1'b0;
    unique case (op)
      OP_PROG, OP_BERASE: begin
        if (supply_low || lock[blk]) reject = 1'b1;
        else                         start_ok = 1'b1;
      end
      OP_CERASE, OP_OTPPROG: begin
        if (supply_low) reject = 1'b1;
        else            start_ok = 1'b1;
      end
      OP_LOCK, OP_UNLOCK: begin
        if (freeze[blk] && !wp_n) reject = 1'b1;
        else                      lock_ok = 1'b1;
      end
      OP_FREEZE: lock_ok = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/flashctl_timer.sv
module flashctl_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          busy,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= len - CW'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign done = busy && (cnt == '0);

endmodule

// File: rtl/flashctl_array.sv
module flashctl_array
  import flashctl_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int WPB       = 4,
  parameter int DATA_W    = 8,
  parameter int OTP_WORDS = 4,
  localparam int NW = NBLK * WPB,
  localparam int AW = $clog2(NW),
  localparam int OW = (OTP_WORDS > 1) ? $clog2(OTP_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  fop_e              op,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] data,
  input  logic [NBLK-1:0]   lock,
  input  logic              rd_otp,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [NW];
  logic [DATA_W-1:0] otp [OTP_WORDS];

  // Cells only move from 1 to 0 on a program
  function automatic logic [DATA_W-1:0] clear_only(logic [DATA_W-1:0] cur,
                                                   logic [DATA_W-1:0] wr);
    return cur & wr;
  endfunction

  function automatic int blk_of(int idx);
    return idx / WPB;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else if (apply) begin
      case (op)
        OP_PROG: mem[addr] <= clear_only(mem[addr], data);
        OP_BERASE: begin
          for (int i = 0; i < NW; i++)
            if (blk_of(i) == blk_of(int'(addr))) mem[i] <= '1;
        end
        OP_CERASE: begin
          for (int i = 0; i < NW; i++)
            if (!lock[blk_of(i)]) mem[i] <= '1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OTP_WORDS; i++) otp[i] <= '1;
    end else if (apply && op == OP_OTPPROG) begin
      otp[addr[OW-1:0]] <= clear_only(otp[addr[OW-1:0]], data);
    end
  end

  assign rd_data = rd_otp ? otp[rd_addr[OW-1:0]] : mem[rd_addr];

endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flashctl_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int WPB       = 4,
  parameter int DATA_W    = 8,
  parameter int OTP_WORDS = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int AW   = $clog2(NBLK * WPB),
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              supply_low,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rd_otp,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status
);

  fop_e              op;
  logic [BW-1:0]     cmd_blk;
  logic              busy, done;
  logic              cmd_take, g_start, g_lock, g_reject;
  logic              wr_start, lock_event, reject_ev, abort_ev, apply;
  logic [NBLK-1:0]   lock, freeze;
  logic              err;
  fop_e              pend_op;
  logic [AW-1:0]     pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [CW-1:0]     cyc_len;

  assign op         = fop_e'(cmd_op);
  assign cmd_blk    = cmd_addr[AW-1 -: BW];
  assign cmd_take   = cmd_valid && !busy;
  assign wr_start   = cmd_take && g_start;
  assign lock_event = cmd_take && g_lock;
  assign reject_ev  = cmd_take && g_reject;
  assign abort_ev   = done && supply_low;
  assign apply      = done && !supply_low;
  assign cyc_len    = is_short_op(op) ? CW'(PROG_CYC) : CW'(ERASE_CYC);

  flashctl_gate #(.NBLK(NBLK)) u_gate (
    .op(op), .blk(cmd_blk), .lock(lock), .freeze(freeze),
    .wp_n(wp_n), .supply_low(supply_low),
    .start_ok(g_start), .lock_ok(g_lock), .reject(g_reject)
  );

  flashctl_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .len(cyc_len),
    .busy(busy), .done(done)
  );

  flashctl_array #(.NBLK(NBLK), .WPB(WPB), .DATA_W(DATA_W),
                   .OTP_WORDS(OTP_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .apply(apply), .op(pend_op),
    .addr(pend_addr), .data(pend_data), .lock(lock),
    .rd_otp(rd_otp), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op   <= OP_CLRSTAT;
      pend_addr <= '0;
      pend_data <= '1;
    end else if (wr_start) begin
      pend_op   <= op;
      pend_addr <= cmd_addr;
      pend_data <= cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock   <= '1;
      freeze <= '0;
    end else if (lock_event) begin
      case (op)
        OP_LOCK:   lock[cmd_blk]   <= 1'b1;
        OP_UNLOCK: lock[cmd_blk]   <= 1'b0;
        OP_FREEZE: freeze[cmd_blk] <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               err <= 1'b0;
    else if (reject_ev || abort_ev)           err <= 1'b1;
    else if (cmd_take && op == OP_CLRSTAT)    err <= 1'b0;
  end

  assign status = {!busy, 2'b00, err, 4'b0000};

endmodule

// File: rtl/flashctl_checks.sv
module flashctl_checks #(
  parameter int NBLK = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wp_n,
  input logic            supply_low,
  input logic [7:0]      status,
  input logic            busy,
  input logic            wr_start,
  input logic            reject_ev,
  input logic [NBLK-1:0] lock,
  input logic [NBLK-1:0] freeze
);

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !status[7]);

  assert_reject_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (status[4] && status[7]));

  assert_no_start_in_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(supply_low));

  assert_locks_hold_while_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lock));

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assert_frozen_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze[b] && !wp_n) |=> $stable(lock[b]));

    assert_freeze_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(freeze[b]));
  end

endmodule

bind flash_prot_ctrl flashctl_checks #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .supply_low(supply_low),
  .status(status), .busy(busy), .wr_start(wr_start), .reject_ev(reject_ev),
  .lock(lock), .freeze(freeze)
);

// File: tb/flash_prot_ctrl_tb.sv
module flash_prot_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 4, WPB = 4, DW = 8, PROG_CYC = 4, ERASE_CYC = 12;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          supply_low = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          rd_otp = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    status;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prot_ctrl #(.NBLK(NBLK), .WPB(WPB), .DATA_W(DW), .OTP_WORDS(4),
                    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .supply_low(supply_low),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_otp(rd_otp), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status)
  );

  function automatic logic [AW-1:0] adr(int b, int w);
    return AW'(b * WPB + w);
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(string req, int act, int exp);
    check(act == exp, req, act, exp);
  endtask

  // Drive one command for one edge; returns at the following negedge
  task automatic do_cmd(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (status[7] == 1'b0 && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(logic otp_sel, logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_otp = otp_sel; rd_addr = a;
    #1 v = rd_data;
    rd_otp = 1'b0;
  endtask

  task automatic run_cmd(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    int n;
    do_cmd(op, a, d);
    wait_ready(n);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R2 status in reset", status, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R2 status after reset", status, 8'h80);
    rd(1'b0, adr(0, 0), v); chk_eq("R10 array word after reset", v, 8'hFF);
    rd(1'b1, 4'd0, v);      chk_eq("R10 otp word after reset", v, 8'hFF);
  endtask

  task automatic t_default_lock();
    logic [DW-1:0] v;
    do_cmd(3'd1, adr(0, 0), 8'h00);
    chk_eq("R8 program to default-locked block rejected", status, 8'h90);
    rd(1'b0, adr(0, 0), v); chk_eq("R8 locked data kept", v, 8'hFF);
    do_cmd(3'd0, '0, '0);
    chk_eq("R11 clear command clears error", status, 8'h80);
  endtask

  task automatic t_program();
    logic [DW-1:0] v;
    int n;
    for (int b = 0; b < NBLK; b++) do_cmd(3'd6, adr(b, 0), '0);
    chk_eq("R7 unlock without freeze accepted", status, 8'h80);
    do_cmd(3'd1, adr(0, 0), 8'hBD);
    chk_eq("R1 ready low after program accept", status[7], 0);
    wait_ready(n);
    chk_eq("R1 program busy cycles", n, PROG_CYC);
    rd(1'b0, adr(0, 0), v); chk_eq("R3 program erased word", v, 8'hBD);
    run_cmd(3'd1, adr(0, 0), 8'hFE);
    rd(1'b0, adr(0, 0), v); chk_eq("R3 single bit clear", v, 8'hBC);
    run_cmd(3'd1, adr(0, 0), 8'hFF);
    rd(1'b0, adr(0, 0), v); chk_eq("R3 all-ones program no change", v, 8'hBC);
    chk_eq("R2 ready after program", status, 8'h80);
  endtask

  task automatic t_berase();
    logic [DW-1:0] v;
    int n;
    run_cmd(3'd1, adr(1, 2), 8'h0F);
    run_cmd(3'd1, adr(0, 3), 8'h55);
    do_cmd(3'd2, adr(0, 1), '0);
    wait_ready(n);
    chk_eq("R1 erase busy cycles", n, ERASE_CYC);
    rd(1'b0, adr(0, 0), v); chk_eq("R4 erased word 0", v, 8'hFF);
    rd(1'b0, adr(0, 3), v); chk_eq("R4 erased word 3", v, 8'hFF);
    rd(1'b0, adr(1, 2), v); chk_eq("R4 other block kept", v, 8'h0F);
  endtask

  task automatic t_locked();
    logic [DW-1:0] v;
    do_cmd(3'd5, adr(1, 0), '0);
    do_cmd(3'd1, adr(1, 2), 8'h00);
    chk_eq("R6 reject keeps ready and sets error", status, 8'h90);
    rd(1'b0, adr(1, 2), v); chk_eq("R6 locked program no change", v, 8'h0F);
    do_cmd(3'd2, adr(1, 0), '0);
    chk_eq("R6 locked erase not busy", status[7], 1);
    rd(1'b0, adr(1, 2), v); chk_eq("R6 locked erase no change", v, 8'h0F);
    run_cmd(3'd1, adr(2, 0), 8'hF0);
    chk_eq("R11 error sticky across good command", status, 8'h90);
    do_cmd(3'd0, '0, '0);
    chk_eq("R11 cleared", status, 8'h80);
  endtask

  task automatic t_cerase();
    logic [DW-1:0] v;
    int n;
    do_cmd(3'd3, '0, '0);
    wait_ready(n);
    chk_eq("R1 chip erase busy cycles", n, ERASE_CYC);
    rd(1'b0, adr(2, 0), v); chk_eq("R5 unlocked block erased", v, 8'hFF);
    rd(1'b0, adr(1, 2), v); chk_eq("R5 locked block kept", v, 8'h0F);
  endtask

  task automatic t_lockdown();
    logic [DW-1:0] v;
    wp_n = 1'b0;
    do_cmd(3'd7, adr(1, 0), '0);
    chk_eq("R8 freeze accepted", status, 8'h80);
    do_cmd(3'd6, adr(1, 0), '0);
    chk_eq("R7 unlock of frozen block refused", status, 8'h90);
    do_cmd(3'd1, adr(1, 2), 8'h00);
    rd(1'b0, adr(1, 2), v); chk_eq("R7 frozen block still locked", v, 8'h0F);
    do_cmd(3'd0, '0, '0);
    do_cmd(3'd5, adr(3, 0), '0);
    do_cmd(3'd6, adr(3, 0), '0);
    chk_eq("R7 unfrozen block lock ops with wp low", status, 8'h80);
    wp_n = 1'b1;
    do_cmd(3'd6, adr(1, 0), '0);
    chk_eq("R7 unlock frozen with wp high", status, 8'h80);
    run_cmd(3'd1, adr(1, 2), 8'h03);
    rd(1'b0, adr(1, 2), v); chk_eq("R7 program after unlock", v, 8'h03);
  endtask

  task automatic t_supply();
    logic [DW-1:0] v;
    int n;
    supply_low = 1'b1;
    do_cmd(3'd1, adr(2, 1), 8'h00);
    chk_eq("R9 program rejected in lockout", status, 8'h90);
    rd(1'b0, adr(2, 1), v); chk_eq("R9 data kept", v, 8'hFF);
    do_cmd(3'd4, 4'd2, 8'h00);
    chk_eq("R9 otp rejected in lockout not busy", status[7], 1);
    rd(1'b1, 4'd2, v); chk_eq("R9 otp kept", v, 8'hFF);
    supply_low = 1'b0;
    do_cmd(3'd0, '0, '0);
    do_cmd(3'd1, adr(2, 1), 8'h00);
    supply_low = 1'b1;
    wait_ready(n);
    supply_low = 1'b0;
    rd(1'b0, adr(2, 1), v); chk_eq("R9 lockout at completion no change", v, 8'hFF);
    chk_eq("R9 lockout at completion error", status, 8'h90);
    do_cmd(3'd0, '0, '0);
  endtask

  task automatic t_otp();
    logic [DW-1:0] v;
    do_cmd(3'd5, adr(0, 0), '0);
    run_cmd(3'd4, 4'd1, 8'hAA);
    chk_eq("R12 otp ignores block lock", status, 8'h80);
    rd(1'b1, 4'd1, v); chk_eq("R12 otp program", v, 8'hAA);
    run_cmd(3'd4, 4'd1, 8'hF0);
    rd(1'b1, 4'd1, v); chk_eq("R12 otp and", v, 8'hA0);
    run_cmd(3'd3, '0, '0);
    rd(1'b1, 4'd1, v); chk_eq("R12 chip erase leaves otp", v, 8'hA0);
  endtask

  task automatic t_busy();
    logic [DW-1:0] v;
    int n;
    do_cmd(3'd6, adr(0, 0), '0);
    do_cmd(3'd1, adr(0, 0), 8'h0F);
    do_cmd(3'd1, adr(0, 1), 8'h00);
    do_cmd(3'd5, adr(0, 0), '0);
    wait_ready(n);
    rd(1'b0, adr(0, 1), v); chk_eq("R13 program while busy ignored", v, 8'hFF);
    rd(1'b0, adr(0, 0), v); chk_eq("R13 first program done", v, 8'h0F);
    run_cmd(3'd1, adr(0, 2), 8'h11);
    rd(1'b0, adr(0, 2), v); chk_eq("R13 lock while busy ignored", v, 8'h11);
  endtask

  task automatic t_reset2();
    logic [DW-1:0] v;
    rst_n = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = '0; cmd_data = '0;
    repeat (2) @(negedge clk);
    chk_eq("R10 command ignored in reset", status, 8'h80);
    cmd_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, adr(0, 0), v); chk_eq("R10 reset restores ones", v, 8'hFF);
    do_cmd(3'd1, adr(2, 0), 8'h00);
    chk_eq("R8 locked again after reset", status, 8'h90);
    do_cmd(3'd0, '0, '0);
    wp_n = 1'b0;
    do_cmd(3'd6, adr(1, 0), '0);
    chk_eq("R8 freeze cleared by reset", status, 8'h80);
    wp_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    report();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_default_lock();
    t_program();
    t_berase();
    t_locked();
    t_cerase();
    t_lockdown();
    t_supply();
    t_otp();
    t_busy();
    t_reset2();
    report();
    $finish;
  end

endmodule